// File: doc/BRIEF.md
# Binary32 Operand Unpacker and Classifier

This block takes one packed single-precision floating-point word and turns it into the wide internal form that an arithmetic datapath works on. The output has five parts: a class code, the sign, a signed exponent with the bias removed, a 64-bit fraction whose leading one sits explicitly in the top bit, and a flag raised when a subnormal input was flushed. Subnormal inputs are normalized into an exponent range that is wider than the packed format's range. A control input can instead force them to zero.

The unit sits in front of an adder, multiplier or divider and runs once per operand. The default build places one register stage after the decode. A parameter can remove that register to give a purely combinational path. A valid bit travels with the data.

Top module: `fpu_operand_unpack`

## Requirements
- R1: An input whose exponent field and fraction field are both zero gives class code 0 (zero), a fraction of 0, an exponent of 0 and a denormal flag of 0.
- R2: An input with a zero exponent field and a nonzero fraction gives class code 0 when `flush_den_i` is 1. The fraction and exponent are forced to 0 and `in_denorm_o` is 1.
- R3: An input with a zero exponent field and a nonzero fraction gives class code 1 (normal) when `flush_den_i` is 0. Let k be the position of the fraction's highest set bit, counted from bit 0 of the 23-bit field. The fraction is shifted left so that bit k lands on output bit 63, and the exponent is k − 149.
- R4: An exponent field E from 1 to 254 gives class code 1. The exponent is E − 127, and the fraction is {1, the 23 stored bits, 40 zeros}.
- R5: An exponent field of 255 with a zero fraction gives class code 2 (infinity), a fraction of 0 and an exponent of 128.
- R6: An exponent field of 255 with a nonzero fraction is a NaN. The class code is 3 (quiet) if fraction bit 22 is set and 4 (signaling) otherwise. The output fraction is {0, the 23 stored bits, 40 zeros} and the exponent is 128.
- R7: `sign_o` equals input bit 31 for every class.
- R8: When REGISTERED=1, the results and `out_valid_o` appear one clock after `in_valid_i`. Reset clears every output to 0.
- R9: `in_denorm_o` is 1 only for a flushed subnormal. `flush_den_i` has no effect on zero, normal, infinity or NaN inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Operand present |
| operand_i | input | 32 | Packed single-precision operand |
| flush_den_i | input | 1 | Treat subnormal inputs as zero |
| out_valid_o | output | 1 | Result present |
| class_o | output | 3 | Class code: 0 zero, 1 normal, 2 infinity, 3 quiet NaN, 4 signaling NaN |
| sign_o | output | 1 | Sign |
| exp_o | output | 10 | Unbiased exponent, two's complement |
| frac_o | output | 64 | Fraction with explicit leading one at bit 63 |
| in_denorm_o | output | 1 | Subnormal input was flushed |

## Verification
Every result and the valid bit are due exactly one rising edge after the operand is applied. The bench drives each operand on a falling edge and compares the whole record on the next falling edge. At that point the single output register has captured the operand, and no newer operand has yet been launched. The reset check samples before any operand is applied. A cycle with the valid input low then confirms that the valid output drops on the following edge.

// File: rtl/fpu_unpk_pkg.sv
package fpu_unpk_pkg;

   typedef enum logic [2:0] {
      CLS_ZERO   = 3'd0,
      CLS_NORMAL = 3'd1,
      CLS_INF    = 3'd2,
      CLS_QNAN   = 3'd3,
      CLS_SNAN   = 3'd4
   } fp_class_e;

endpackage

// File: rtl/fpu_unpk_lzc.sv
module fpu_unpk_lzc #(
   parameter int W  = 23,
   parameter int CW = $clog2(W + 1)
) (
   input  logic [W-1:0]  in_i,
   output logic [CW-1:0] cnt_o
);

   if (W < 2) begin : g_bad_w
      $error("fpu_unpk_lzc: W must be at least 2");
   end

   always_comb begin
      cnt_o = CW'(W);
      for (int i = 0; i < W; i++) begin
         if (in_i[i]) cnt_o = CW'(W - 1 - i);
      end
   end

endmodule

// File: rtl/fpu_unpk_decode.sv
module fpu_unpk_decode
   import fpu_unpk_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int MAN_W  = 23,
   parameter int FRAC_W = 64,
   parameter int EXPO_W = EXP_W + 2
) (
   input  logic [EXP_W+MAN_W:0]     operand_i,
   input  logic                     flush_den_i,
   output logic [2:0]               class_o,
   output logic                     sign_o,
   output logic signed [EXPO_W-1:0] exp_o,
   output logic [FRAC_W-1:0]        frac_o,
   output logic                     in_denorm_o
);

   localparam int BIAS = (1 << (EXP_W - 1)) - 1;
   localparam int PAD  = FRAC_W - 1 - MAN_W;
   localparam int CW   = $clog2(MAN_W + 1);

   if (PAD < 1) begin : g_bad_frac
      $error("fpu_unpk_decode: FRAC_W must exceed MAN_W + 1");
   end
   if (EXPO_W < EXP_W + 2) begin : g_bad_expo
      $error("fpu_unpk_decode: EXPO_W too narrow for subnormal range");
   end

   logic [EXP_W-1:0] exp_fld;
   logic [MAN_W-1:0] man_fld;
   logic             exp_zero, exp_ones, man_zero;
   logic [CW-1:0]    lz;
   logic [MAN_W-1:0] man_norm;
   logic signed [EXPO_W-1:0] exp_biased_rm, exp_sub;

   assign sign_o   = operand_i[EXP_W+MAN_W];
   assign exp_fld  = operand_i[EXP_W+MAN_W-1:MAN_W];
   assign man_fld  = operand_i[MAN_W-1:0];
   assign exp_zero = (exp_fld == '0);
   assign exp_ones = (exp_fld == '1);
   assign man_zero = (man_fld == '0);

   fpu_unpk_lzc #(.W(MAN_W), .CW(CW)) lzc_i (
      .in_i  (man_fld),
      .cnt_o (lz)
   );

   // shift past the leading one; it becomes the explicit top bit
   assign man_norm      = man_fld << ({1'b0, lz} + 1'b1);
   assign exp_biased_rm = $signed(EXPO_W'(exp_fld)) - $signed(EXPO_W'(BIAS));
   assign exp_sub       = $signed(EXPO_W'(0)) - $signed(EXPO_W'(BIAS))
                          - $signed(EXPO_W'(lz));

   always_comb begin
      class_o     = CLS_ZERO;
      exp_o       = '0;
      frac_o      = '0;
      in_denorm_o = 1'b0;
      if (exp_zero) begin
         if (!man_zero) begin
            if (flush_den_i) begin
               in_denorm_o = 1'b1;
            end else begin
               class_o = CLS_NORMAL;
               exp_o   = exp_sub;
               frac_o  = {1'b1, man_norm, {PAD{1'b0}}};
            end
         end
      end else if (!exp_ones) begin
         class_o = CLS_NORMAL;
         exp_o   = exp_biased_rm;
         frac_o  = {1'b1, man_fld, {PAD{1'b0}}};
      end else if (man_zero) begin
         class_o = CLS_INF;
         exp_o   = exp_biased_rm;
      end else begin
         class_o = man_fld[MAN_W-1] ? CLS_QNAN : CLS_SNAN;
         exp_o   = exp_biased_rm;
         frac_o  = {1'b0, man_fld, {PAD{1'b0}}};
      end
   end

endmodule

// File: rtl/fpu_operand_unpack.sv
module fpu_operand_unpack #(
   parameter int EXP_W     = 8,
   parameter int MAN_W     = 23,
   parameter int FRAC_W    = 64,
   parameter bit REGISTERED = 1'b1,
   localparam int OP_W     = EXP_W + MAN_W + 1,
   localparam int EXPO_W   = EXP_W + 2
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     in_valid_i,
   input  logic [OP_W-1:0]          operand_i,
   input  logic                     flush_den_i,
   output logic                     out_valid_o,
   output logic [2:0]               class_o,
   output logic                     sign_o,
   output logic signed [EXPO_W-1:0] exp_o,
   output logic [FRAC_W-1:0]        frac_o,
   output logic                     in_denorm_o
);

   logic [2:0]               d_class;
   logic                     d_sign;
   logic signed [EXPO_W-1:0] d_exp;
   logic [FRAC_W-1:0]        d_frac;
   logic                     d_den;

   fpu_unpk_decode #(
      .EXP_W(EXP_W), .MAN_W(MAN_W), .FRAC_W(FRAC_W), .EXPO_W(EXPO_W)
   ) dec_i (
      .operand_i   (operand_i),
      .flush_den_i (flush_den_i),
      .class_o     (d_class),
      .sign_o      (d_sign),
      .exp_o       (d_exp),
      .frac_o      (d_frac),
      .in_denorm_o (d_den)
   );

   if (REGISTERED) begin : g_reg
      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            out_valid_o <= 1'b0;
            class_o     <= '0;
            sign_o      <= 1'b0;
            exp_o       <= '0;
            frac_o      <= '0;
            in_denorm_o <= 1'b0;
         end else begin
            out_valid_o <= in_valid_i;
            class_o     <= d_class;
            sign_o      <= d_sign;
            exp_o       <= d_exp;
            frac_o      <= d_frac;
            in_denorm_o <= d_den & in_valid_i;
         end
      end
   end else begin : g_comb
      assign out_valid_o = in_valid_i;
      assign class_o     = d_class;
      assign sign_o      = d_sign;
      assign exp_o       = d_exp;
      assign frac_o      = d_frac;
      assign in_denorm_o = d_den & in_valid_i;
   end

endmodule

// File: rtl/fpu_operand_unpack_chk.sv
module fpu_operand_unpack_chk
   import fpu_unpk_pkg::*;
#(
   parameter int EXP_W      = 8,
   parameter int MAN_W      = 23,
   parameter int FRAC_W     = 64,
   parameter bit REGISTERED = 1'b1,
   localparam int OP_W      = EXP_W + MAN_W + 1,
   localparam int EXPO_W    = EXP_W + 2
) (
   input logic                     clk_i,
   input logic                     rst_ni,
   input logic                     in_valid_i,
   input logic [OP_W-1:0]          operand_i,
   input logic                     flush_den_i,
   input logic                     out_valid_o,
   input logic [2:0]               class_o,
   input logic                     sign_o,
   input logic signed [EXPO_W-1:0] exp_o,
   input logic [FRAC_W-1:0]        frac_o,
   input logic                     in_denorm_o
);

   localparam int QBIT = FRAC_W - 2;

   AST_ZERO_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (class_o == CLS_ZERO) |-> (frac_o == '0 && exp_o == '0)); // R1

   AST_FLUSH_IS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_denorm_o |-> (class_o == CLS_ZERO && out_valid_o)); // R2

   AST_NORMAL_LEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (class_o == CLS_NORMAL) |-> frac_o[FRAC_W-1]); // R4

   AST_INF_FRAC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (class_o == CLS_INF) |-> (frac_o == '0)); // R5

   AST_QNAN_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (class_o == CLS_QNAN) |-> (frac_o[QBIT] && !frac_o[FRAC_W-1])); // R6

   AST_SNAN_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (class_o == CLS_SNAN) |-> (!frac_o[QBIT] && frac_o != '0)); // R6

   AST_CLASS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      class_o <= 3'd4); // R9

   if (REGISTERED) begin : g_seq
      AST_SIGN_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
         out_valid_o |=> (!out_valid_o || sign_o == $past(operand_i[OP_W-1]))); // R7

      AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
         in_valid_i |=> out_valid_o); // R8

      AST_DEN_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (in_valid_i && !flush_den_i) |=> !in_denorm_o); // R9
   end else begin : g_cmb
      AST_SIGN_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
         out_valid_o |-> (sign_o == operand_i[OP_W-1])); // R7

      AST_DEN_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !flush_den_i |-> !in_denorm_o); // R9
   end

endmodule

bind fpu_operand_unpack fpu_operand_unpack_chk #(
   .EXP_W(EXP_W), .MAN_W(MAN_W), .FRAC_W(FRAC_W), .REGISTERED(REGISTERED)
) chk_i (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .in_valid_i  (in_valid_i),
   .operand_i   (operand_i),
   .flush_den_i (flush_den_i),
   .out_valid_o (out_valid_o),
   .class_o     (class_o),
   .sign_o      (sign_o),
   .exp_o       (exp_o),
   .frac_o      (frac_o),
   .in_denorm_o (in_denorm_o)
);

// File: tb/fpu_operand_unpack_tb_top.sv
`timescale 1ns/1ps
module fpu_operand_unpack_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] operand = '0;
   logic        flush = 1'b0;
   logic        out_valid;
   logic [2:0]  cls;
   logic        sgn;
   logic signed [9:0] ex;
   logic [63:0] frac;
   logic        den;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   fpu_operand_unpack dut_i (
      .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .operand_i(operand),
      .flush_den_i(flush), .out_valid_o(out_valid), .class_o(cls), .sign_o(sgn),
      .exp_o(ex), .frac_o(frac), .in_denorm_o(den)
   );

   // expected record: {class[2:0], sign, exp[9:0], frac[63:0], den}
   function automatic logic [78:0] model(input logic [31:0] op, input logic fl);
      logic [7:0]  e  = op[30:23];
      logic [22:0] m  = op[22:0];
      logic [2:0]  c  = 3'd0;
      int          xe = 0;
      logic [63:0] f  = '0;
      logic        d  = 1'b0;
      int          k  = -1;
      if (e == 8'd0) begin
         if (m != 0) begin
            if (fl) d = 1'b1;
            else begin
               for (int i = 0; i < 23; i++) if (m[i]) k = i;
               c  = 3'd1;
               xe = k - 149;
               f  = {41'd0, m} << (63 - k);
            end
         end
      end else if (e != 8'hFF) begin
         c = 3'd1; xe = int'(e) - 127; f = {1'b1, m, 40'd0};
      end else if (m == 0) begin
         c = 3'd2; xe = 128;
      end else begin
         c = m[22] ? 3'd3 : 3'd4; xe = 128; f = {1'b0, m, 40'd0};
      end
      return {c, op[31], 10'(xe), f, d};
   endfunction

   function automatic string req_of(input logic [31:0] op, input logic fl);
      if (op[30:23] == 8'd0)  return (op[22:0] == 0) ? "R1" : (fl ? "R2" : "R3");
      if (op[30:23] == 8'hFF) return (op[22:0] == 0) ? "R5" : "R6";
      return "R4";
   endfunction

   task automatic apply(input logic [31:0] op, input logic fl);
      logic [78:0] exp_rec, got;
      @(negedge clk);
      operand  = op;
      flush    = fl;
      in_valid = 1'b1;
      exp_rec  = model(op, fl);
      @(negedge clk);
      got = {cls, sgn, ex, frac, den};
      n_chk++;
      if (got !== exp_rec || out_valid !== 1'b1) begin
         n_bad++;
         $display("FAIL %s/R7/R8/R9 op=%h fl=%0b got=%h v=%0b exp=%h v=1",
                  req_of(op, fl), op, fl, got, out_valid, exp_rec);
      end
   endtask

   initial begin
      #200000;
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int unsigned r;
      logic [31:0] op;
      r = $urandom(32'd20240611);
      repeat (3) @(negedge clk);
      // R8 reset state
      n_chk++;
      if ({out_valid, cls, sgn, ex, frac, den} !== '0) begin
         n_bad++;
         $display("FAIL R8 reset got=%h exp=0", {out_valid, cls, sgn, ex, frac, den});
      end
      rst_n = 1'b1;

      // directed corners
      apply(32'h0000_0000, 1'b0);  // R1 +0
      apply(32'h8000_0000, 1'b1);  // R1 -0 with flush, R9
      apply(32'h0000_0001, 1'b0);  // R3 smallest subnormal
      apply(32'h807F_FFFF, 1'b0);  // R3 largest subnormal, R7
      apply(32'h0040_0000, 1'b0);  // R3
      apply(32'h0000_0001, 1'b1);  // R2
      apply(32'h807F_FFFF, 1'b1);  // R2 R7
      apply(32'h3F80_0000, 1'b1);  // R4 1.0, R9 flush ignored
      apply(32'h0080_0000, 1'b0);  // R4 smallest normal
      apply(32'hFF7F_FFFF, 1'b0);  // R4 largest normal
      apply(32'h7F80_0000, 1'b1);  // R5 R9
      apply(32'hFF80_0000, 1'b0);  // R5 R7
      apply(32'h7FC0_0000, 1'b0);  // R6 quiet
      apply(32'h7F80_0001, 1'b1);  // R6 signaling, R9
      apply(32'hFFBF_FFFF, 1'b0);  // R6 signaling
      apply(32'hFFFF_FFFF, 1'b0);  // R6 quiet

      // R8 valid drops one cycle after in_valid falls
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      n_chk++;
      if (out_valid !== 1'b0) begin
         n_bad++;
         $display("FAIL R8 out_valid got=%0b exp=0", out_valid);
      end

      // constrained random
      for (int n = 0; n < 600; n++) begin
         op = $urandom;
         case ($urandom % 5)
            0: op[30:23] = 8'h00;
            1: op[30:23] = 8'hFF;
            2: begin op[30:23] = 8'h00; op[22:0] = 23'd1 << ($urandom % 23); end
            default: ;
         endcase
         if ($urandom % 8 == 0) op[22:0] = '0;
         apply(op, 1'($urandom));
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule